// File: doc/BRIEF.md
# Packed Sign-Bit Test Flag Unit

This unit produces the zero and carry condition flags for a packed sign-bit test between two vector operands of up to 256 bits. Only the most significant bit of each active lane is used. The zero flag reports whether the first and second operands share no set sign bit. The carry flag reports whether no lane has its sign bit set in the second operand while that bit is clear in the first operand. The overflow, sign, auxiliary and parity flags are cleared on every successful operation. Neither operand is written back.

Each request carries several fields: the two operands, a vector-length select, the opcode byte (which also selects the lane size) and the decoded prefix fields. The unit checks that the encoding is legal. An illegal encoding raises an invalid-opcode indication and updates no flags. Requests enter through a valid/ready handshake and land in a single registered output stage. That stage holds its result until the consumer takes it.

Top module: `sgntest_flag_unit`

## Requirements
- R1: `zf` is 1 exactly when, in every active lane, the sign bit of `opnd_b AND opnd_a` is 0. Otherwise `zf` is 0.
- R2: `cf` is 1 exactly when, in every active lane, the sign bit of `opnd_b AND NOT opnd_a` is 0. Otherwise `cf` is 0.
- R3: With 64-bit lanes the examined bits are 63 and 127 when `wide_sel`=0, and 63, 127, 191 and 255 when `wide_sel`=1. Other bits, such as bit 95, have no effect.
- R4: With 32-bit lanes the examined bits are 32*k+31, for k from 0 to 3 when `wide_sel`=0 and for k from 0 to 7 when `wide_sel`=1.
- R5: When `wide_sel`=0, bits 255:128 of both operands have no effect on `zf` or `cf`.
- R6: A legal request sets `flag_we`=1 and `ud`=0, and drives `of`, `sf`, `af` and `pf` to 0.
- R7: `opcode_byte` 0x0E selects 32-bit lanes and 0x0F selects 64-bit lanes. The encoding is legal only when `pfx_66`=1 and `map_0f38`=1. Any other opcode byte, or a missing prefix or map, raises `ud`.
- R8: `vex_w`=1 raises `ud`.
- R9: `vex_vvvv` other than 4'b1111 raises `ud`.
- R10: On a request that raises `ud`, `zf` and `cf` keep their previous values and `flag_we`=0.
- R11: A request is taken on a rising edge where `in_valid` and `in_ready` are both 1. Its result shows one cycle later with `out_valid`=1. `in_ready` is 0 while `out_valid` is 1.
- R12: While `out_valid`=1 and `out_ready`=0, `out_valid` and all result outputs stay unchanged. A cycle with `out_ready`=1 clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| opnd_a | input | 256 | First operand |
| opnd_b | input | 256 | Second operand |
| wide_sel | input | 1 | 1 = 256-bit vector, 0 = 128-bit vector |
| opcode_byte | input | 8 | Opcode byte, selects the lane size |
| pfx_66 | input | 1 | Operand-size prefix field present |
| map_0f38 | input | 1 | Opcode map is the three-byte 0F38 map |
| vex_w | input | 1 | Width bit of the vector prefix |
| vex_vvvv | input | 4 | Extra register field of the vector prefix |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| af | output | 1 | Auxiliary flag |
| pf | output | 1 | Parity flag |
| flag_we | output | 1 | Flags are to be written |
| ud | output | 1 | Invalid-opcode indication |

## Verification
A request driven at a falling edge is taken at the next rising edge. All of its results (`out_valid`, `zf`, `cf`, the cleared flags, `flag_we` and `ud`) are due after that single register stage. The bench samples them at the falling edge that follows. During a stall the bench samples again at every falling edge and expects values identical to the first sample. One cycle after it raises `out_ready`, it expects `out_valid` to have dropped. The reference model tracks the last legal flag pair so that the held values after an illegal request are predicted. It also derives the "neither zero nor carry" form from its own results and compares that form on every result.

// File: rtl/sgntest_pkg.sv
// Package: shared widths, opcode values and the flag-pair type of the
// packed sign-bit test flag unit. Assumes lanes are 32 or 64 bits wide.
package sgntest_pkg;
    localparam int unsigned VEC_W_MAX  = 256;
    localparam int unsigned SLOT_W     = 32;
    localparam logic [7:0]  OPC_LANE32 = 8'h0E;
    localparam logic [7:0]  OPC_LANE64 = 8'h0F;
    localparam logic [3:0]  VVVV_UNUSED = 4'b1111;

    typedef struct packed {
        logic zf;
        logic cf;
    } flag_pair_t;
endpackage

// File: rtl/sgntest_decode.sv
// Module: checks that the encoding fields describe a legal packed sign-bit
// test and derives the lane size from the opcode byte. Purely combinational;
// clk and rst_n only clock the local assertions.
module sgntest_decode
    import sgntest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] opcode_byte,
    input  logic       pfx_66,
    input  logic       map_0f38,
    input  logic       vex_w,
    input  logic [3:0] vex_vvvv,
    output logic       lane64,
    output logic       illegal
);
    logic opc_known;

    // Recognise the two opcode values and pick the lane size.
    always_comb begin
        opc_known = (opcode_byte == OPC_LANE32) || (opcode_byte == OPC_LANE64);
        lane64    = (opcode_byte == OPC_LANE64);
    end

    // Combine every legality rule into one illegal indication.
    always_comb begin
        illegal = !opc_known || !pfx_66 || !map_0f38 || vex_w ||
                  (vex_vvvv != VVVV_UNUSED);
    end

    // R8: a set width bit must never pass as legal.
    assert_w_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vex_w |-> illegal);

    // R9: any used extra register field must never pass as legal.
    assert_vvvv_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vex_vvvv != 4'b1111) |-> illegal);

    // R7: a legal encoding always carries one of the two opcodes.
    assert_opcode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal |-> (opcode_byte[7:1] == 7'h07));
endmodule

// File: rtl/sgntest_sign_reduce.sv
// Module: gathers the sign bit of every 32-bit slot and masks the slots
// that are active for the selected vector length and lane size. It then
// reduces the AND and AND-NOT terms into the zero and carry flags. A 64-bit
// lane's sign bit is the sign bit of its upper 32-bit slot.
module sgntest_sign_reduce
    import sgntest_pkg::*;
#(
    parameter int unsigned VEC_W = VEC_W_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic             wide,
    input  logic             lane64,
    output flag_pair_t       flags
);
    localparam int unsigned NSLOT      = VEC_W / SLOT_W;
    localparam int unsigned NSLOT_HALF = NSLOT / 2;

    logic [NSLOT-1:0] act_mask;
    logic [NSLOT-1:0] and_sign;
    logic [NSLOT-1:0] andn_sign;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int unsigned MSB = s * SLOT_W + SLOT_W - 1;
        // Decide whether this slot's sign bit counts, and form both terms.
        always_comb begin
            act_mask[s]  = (wide || (s < NSLOT_HALF)) &&
                           (!lane64 || ((s % 2) == 1));
            and_sign[s]  = opb[MSB] & opa[MSB];
            andn_sign[s] = opb[MSB] & ~opa[MSB];
        end
    end

    // Reduce the masked terms into the two flags.
    always_comb begin
        flags.zf = ~|(and_sign & act_mask);
        flags.cf = ~|(andn_sign & act_mask);
    end

    // R3/R4: the number of active lanes follows vector length and lane size.
    assert_active_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_mask) == ((wide ? NSLOT : NSLOT_HALF) >> lane64));

    // R5: in 128-bit mode no slot of the upper half takes part.
    assert_upper_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (act_mask[NSLOT-1:NSLOT_HALF] == '0));
endmodule

// File: rtl/sgntest_out_stage.sv
// Module: single registered result stage with a valid/ready handshake.
// Takes a request only while empty, so in_ready is simply "not holding".
// An illegal request records ud and keeps the previous zero and carry flags.
module sgntest_out_stage
    import sgntest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_legal,
    input  flag_pair_t in_flags,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       zf,
    output logic       cf,
    output logic       of,
    output logic       sf,
    output logic       af,
    output logic       pf,
    output logic       flag_we,
    output logic       ud
);
    logic take;

    // Accept only when the stage is empty.
    always_comb begin
        in_ready = !out_valid;
        take     = in_valid && in_ready;
    end

    // Track whether a result is held.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (take)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Capture the result fields of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zf <= 1'b0; cf <= 1'b0;
            of <= 1'b0; sf <= 1'b0; af <= 1'b0; pf <= 1'b0;
            flag_we <= 1'b0; ud <= 1'b0;
        end else if (take) begin
            flag_we <= in_legal;
            ud      <= !in_legal;
            if (in_legal) begin
                zf <= in_flags.zf; cf <= in_flags.cf;
                of <= 1'b0; sf <= 1'b0; af <= 1'b0; pf <= 1'b0;
            end
        end
    end

    // R11: an accepted request shows its result on the next cycle.
    assert_result_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R11: no request is accepted while a result is held.
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R12: a stalled result stays put.
    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({zf, cf, flag_we, ud})));

    // R10: an illegal request leaves zf and cf untouched and blocks the write.
    assert_ud_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_legal) |=> (ud && !flag_we && $stable(zf) && $stable(cf)));

    // R6: a written result never carries a set overflow, sign, aux or parity flag.
    assert_clear_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_we) |-> !(of || sf || af || pf));
endmodule

// File: rtl/sgntest_flag_unit.sv
// Module: top of the packed sign-bit test flag unit. Decodes the encoding,
// reduces the lane sign bits and registers the flags behind a valid/ready
// handshake. Assumes a synchronous active-low reset.
module sgntest_flag_unit
    import sgntest_pkg::*;
#(
    parameter int unsigned VEC_W = VEC_W_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    input  logic             wide_sel,
    input  logic [7:0]       opcode_byte,
    input  logic             pfx_66,
    input  logic             map_0f38,
    input  logic             vex_w,
    input  logic [3:0]       vex_vvvv,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             zf,
    output logic             cf,
    output logic             of,
    output logic             sf,
    output logic             af,
    output logic             pf,
    output logic             flag_we,
    output logic             ud
);
    logic       lane64;
    logic       illegal;
    flag_pair_t flags;

    sgntest_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode_byte (opcode_byte),
        .pfx_66      (pfx_66),
        .map_0f38    (map_0f38),
        .vex_w       (vex_w),
        .vex_vvvv    (vex_vvvv),
        .lane64      (lane64),
        .illegal     (illegal)
    );

    sgntest_sign_reduce #(.VEC_W(VEC_W)) u_reduce (
        .clk    (clk),
        .rst_n  (rst_n),
        .opa    (opnd_a),
        .opb    (opnd_b),
        .wide   (wide_sel),
        .lane64 (lane64),
        .flags  (flags)
    );

    sgntest_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_legal  (!illegal),
        .in_flags  (flags),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .zf        (zf),
        .cf        (cf),
        .of        (of),
        .sf        (sf),
        .af        (af),
        .pf        (pf),
        .flag_we   (flag_we),
        .ud        (ud)
    );
endmodule

// File: tb/sgntest_flag_unit_tb.sv
`timescale 1ns/1ps
// Bench: drives requests at falling edges and predicts every output with a
// behavioural model. It samples the single registered stage one edge later.
module sgntest_flag_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] opnd_a = '0;
    logic [255:0] opnd_b = '0;
    logic         wide_sel = 1'b0;
    logic [7:0]   opcode_byte = 8'h0F;
    logic         pfx_66 = 1'b1;
    logic         map_0f38 = 1'b1;
    logic         vex_w = 1'b0;
    logic [3:0]   vex_vvvv = 4'hF;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         zf, cf, of, sf, af, pf, flag_we, ud;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit ref_zf = 1'b0;
    bit ref_cf = 1'b0;

    always #2 clk = ~clk;

    sgntest_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_sel(wide_sel),
        .opcode_byte(opcode_byte), .pfx_66(pfx_66), .map_0f38(map_0f38),
        .vex_w(vex_w), .vex_vvvv(vex_vvvv), .out_valid(out_valid),
        .out_ready(out_ready), .zf(zf), .cf(cf), .of(of), .sf(sf), .af(af),
        .pf(pf), .flag_we(flag_we), .ud(ud)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            report();
        end
    end

    // Reference: walk the active lanes and test the sign bits.
    task automatic model(input logic [255:0] a, input logic [255:0] b, input bit wide,
                         input bit l64, output bit mz, output bit mc);
        int lw = l64 ? 64 : 32;
        int nl = (wide ? 256 : 128) / lw;
        mz = 1'b1; mc = 1'b1;
        for (int k = 0; k < nl; k++) begin
            int p = k * lw + lw - 1;
            if (b[p] && a[p])  mz = 1'b0;
            if (b[p] && !a[p]) mc = 1'b0;
        end
    endtask

    task automatic run_op(input logic [255:0] a, input logic [255:0] b, input bit wide,
                          input logic [7:0] opc, input bit p66, input bit m38,
                          input bit w, input logic [3:0] vv, input int stall, input string tag);
        bit legal, mz, mc;
        logic [3:0] snap;
        legal = p66 && m38 && !w && (vv == 4'hF) && (opc == 8'h0E || opc == 8'h0F);
        if (legal) begin
            model(a, b, wide, opc == 8'h0F, mz, mc);
            ref_zf = mz; ref_cf = mc;
        end
        @(negedge clk);
        opnd_a = a; opnd_b = b; wide_sel = wide; opcode_byte = opc;
        pfx_66 = p66; map_0f38 = m38; vex_w = w; vex_vvvv = vv;
        in_valid = 1'b1; out_ready = 1'b0;
        chk(in_ready == 1'b1, {"R11 in_ready idle ", tag}, in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {"R11 out_valid ", tag}, out_valid, 1);
        chk(in_ready == 1'b0, {"R11 busy ", tag}, in_ready, 0);
        chk(zf == ref_zf, {"R1 zf ", tag}, zf, ref_zf);
        chk(cf == ref_cf, {"R2 cf ", tag}, cf, ref_cf);
        chk((!zf && !cf) == (!ref_zf && !ref_cf), {"R1 R2 nzc ", tag}, !zf && !cf, !ref_zf && !ref_cf);
        chk(ud == !legal, {"R7 R8 R9 ud ", tag}, ud, !legal);
        chk(flag_we == legal, {"R10 flag_we ", tag}, flag_we, legal);
        if (legal)
            chk({of, sf, af, pf} == 4'b0, {"R6 cleared ", tag}, {of, sf, af, pf}, 0);
        snap = {zf, cf, flag_we, ud};
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(out_valid && ({zf, cf, flag_we, ud} == snap), {"R12 hold ", tag},
                {out_valid, zf, cf, flag_we, ud}, {1'b1, snap});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, {"R12 drain ", tag}, out_valid, 0);
    endtask

    initial begin
        logic [255:0] ra, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready && !zf && !cf && !flag_we && !ud, "R11 reset state",
            {out_valid, in_ready, zf, cf, flag_we, ud}, 6'b010000);

        // Directed cases for lane positions and modes.
        run_op(256'h1 << 63, 256'h1 << 63, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R3 d128 bit63 shared");
        run_op('0, 256'h1 << 127, 0, 8'h0F, 1, 1, 0, 4'hF, 2, "R3 d128 bit127 b only");
        run_op(256'h1 << 95, 256'h1 << 95, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R3 d128 bit95 not a sign");
        run_op(256'h1 << 95, 256'h1 << 95, 0, 8'h0E, 1, 1, 0, 4'hF, 0, "R4 s128 bit95 shared");
        run_op('0, 256'h1 << 191, 1, 8'h0F, 1, 1, 0, 4'hF, 1, "R3 d256 bit191 b only");
        run_op(256'h1 << 223, 256'h1 << 223, 1, 8'h0E, 1, 1, 0, 4'hF, 0, "R4 s256 bit223 shared");
        run_op({4{64'h8000_0000_8000_0000}} & ~256'h0 , {2{128'h8000_0000_0000_0000_0000_0000_0000_0000}}, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R1 d128 all shared");
        run_op(256'h1 << 255, 256'h1 << 255, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R5 upper ignored d");
        run_op('0, {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h0}, 0, 8'h0E, 1, 1, 0, 4'hF, 0, "R5 upper ignored s");

        // Illegal encodings after a flag-setting op: flags must hold.
        run_op(256'h1 << 63, 256'h1 << 63, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R10 setup");
        run_op('0, '0, 0, 8'h0F, 1, 1, 1, 4'hF, 1, "R8 W set");
        run_op('0, '0, 0, 8'h0E, 1, 1, 0, 4'hE, 0, "R9 vvvv 1110");
        run_op('0, '0, 1, 8'h10, 1, 1, 0, 4'hF, 0, "R7 bad opcode");
        run_op('0, '0, 0, 8'h0F, 0, 1, 0, 4'hF, 0, "R7 no prefix");
        run_op('0, '0, 0, 8'h0F, 1, 0, 0, 4'hF, 0, "R7 wrong map");
        run_op('0, '0, 0, 8'h0F, 1, 1, 0, 4'hF, 0, "R6 after ud");

        // Random operands over both lane sizes and both lengths.
        for (int n = 0; n < 80; n++) begin
            for (int q = 0; q < 8; q++) begin
                ra[q*32 +: 32] = $urandom;
                rb[q*32 +: 32] = $urandom;
            end
            run_op(ra, rb, n[0], n[1] ? 8'h0F : 8'h0E, 1, 1, 0, 4'hF, n % 3, "R1 R2 random");
        end
        report();
    end
endmodule